// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Status Flags

This block is the arithmetic execution stage of a small load/store processor. Each accepted operation adds or subtracts two operands: the first always comes from the register file, the second comes from the register file or from a short immediate field. The immediate is widened to the data width by zero extension by default, or by sign extension when requested. An optional carry-in, taken from the stored carry flag, lets software chain multiword adds and subtracts. A plain operation handles the low word and the carry-using variant handles each higher word.

The result and four status flags (negative, carry, overflow, zero) appear one clock after the input strobe. The flags are kept in a status register. That register is written on every accepted operation unless the instruction sets its hold bit. When the hold bit is set the result is still produced and the old flags stay. After a subtraction the carry flag means "borrow": it is set exactly when the first operand is unsigned-lower than the second operand plus the carry-in.

Top module: `aau_addsub_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `result`, `out_valid` and all four flags become 0.
- R2: With `op_sub`=0 (add), `result` = (A + B + cin) mod 2^DATA_W and `flag_c` = carry out of the most significant bit.
- R3: With `op_sub`=1 (subtract), `result` = (A - B - cin) mod 2^DATA_W and `flag_c` = 1 exactly when A < B + cin, read as unsigned numbers.
- R4: cin is the stored `flag_c` when `use_carry`=1 and 0 when `use_carry`=0, so a carry left by a low-word add propagates into the following high-word add.
- R5: `flag_n` equals bit DATA_W-1 of the result and `flag_z` is 1 exactly when the result is all zeros.
- R6: `flag_v` is set for add when A[MSB]==B[MSB] and R[MSB]!=A[MSB], and for subtract when A[MSB]!=B[MSB] and R[MSB]!=A[MSB].
- R7: When `flag_hold`=1 on an accepted operation, all four flags keep their previous values and `result` is still updated.
- R8: With `use_imm`=1 the second operand is `imm`, zero-extended when `sign_ext`=0 and extended with its bit IMM_W-1 when `sign_ext`=1; `src_b` is then ignored.
- R9: `out_valid` is high in the cycle after each cycle in which `in_valid` is high and low otherwise; with `in_valid` low, `result` and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| use_imm | input | 1 | Second operand from `imm` instead of `src_b` |
| use_carry | input | 1 | Use the stored carry flag as carry-in |
| sign_ext | input | 1 | Sign-extend the immediate (0 = zero-extend) |
| flag_hold | input | 1 | Suppress the status register update |
| src_a | input | DATA_W | First operand |
| src_b | input | DATA_W | Second register operand |
| imm | input | IMM_W | Immediate field |
| out_valid | output | 1 | Result and flags valid |
| result | output | DATA_W | Registered sum or difference |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry / borrow flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_z | output | 1 | Zero flag |

## Verification
Some properties are checked by the assertions on every cycle. These are the strobe-to-valid timing, the stability of the flags when a cycle is idle or the hold bit is set, the agreement of the negative and zero flags with the registered result after each update, and the shape of the widened immediate. Whether the sum, the borrow sense of the carry, the overflow rule and the carry chaining across operations are correct can only be shown by the bench. It sweeps an 8-bit instance across a grid of operand pairs that includes the extremes, with all mode bits, and across every 4-bit immediate in both extension modes. It compares each result against arithmetic done in the bench, which keeps its own copy of the flags.

// File: rtl/aau_pkg.sv
// Package: shared types for the add/subtract unit.
// Assumes: flags are always handled as one group of four bits.
package aau_pkg;

    // Status flag group held in the status register.
    typedef struct packed {
        logic n;   // negative
        logic c;   // carry out, or borrow after subtract
        logic v;   // signed overflow
        logic z;   // zero result
    } aau_flags_t;

    localparam aau_flags_t AAU_FLAGS_CLEAR = '{n: 1'b0, c: 1'b0, v: 1'b0, z: 1'b0};

endpackage

// File: rtl/aau_operand_sel.sv
// Module: aau_operand_sel
// Picks the second operand: the register operand, or the immediate widened
// to DATA_W by zero or sign extension.
// Assumes: IMM_W < DATA_W.
module aau_operand_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12
) (
    input  logic              use_imm,
    input  logic              sign_ext,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_wide;
    logic              fill_bit;

    // Widen the immediate with either zeros or copies of its top bit.
    always_comb begin
        fill_bit = sign_ext & imm[IMM_W-1];
        imm_wide = {{EXT_W{fill_bit}}, imm};
    end

    // Route the chosen source to the adder.
    always_comb begin
        opnd_b = use_imm ? imm_wide : reg_b;
    end

    // Check the extension bits against the immediate field.
    always_comb begin
        if (use_imm === 1'b1 && sign_ext === 1'b0)
            AST_IMM_ZERO_EXT: assert (opnd_b[DATA_W-1:IMM_W] == '0); // R8
        if (use_imm === 1'b1 && sign_ext === 1'b1 && imm[IMM_W-1] === 1'b1)
            AST_IMM_SIGN_EXT: assert (&opnd_b[DATA_W-1:IMM_W]); // R8
    end
endmodule

// File: rtl/aau_adder.sv
// Module: aau_adder
// Combinational add or subtract with carry-in. It gives the result, the
// carry (borrow when subtracting) and signed overflow.
// Assumes: cin is already gated by the carry-use bit.
module aau_adder #(
    parameter int DATA_W = 32
) (
    input  logic              sub,
    input  logic              cin,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              ovf
);
    localparam int WIDE_W = DATA_W + 1;
    localparam int MSB    = DATA_W - 1;

    logic [WIDE_W-1:0] wide;
    logic [WIDE_W-1:0] cin_wide;

    // One extra bit holds the carry out, or the borrow of a difference.
    always_comb begin
        cin_wide = {{DATA_W{1'b0}}, cin};
        if (sub)
            wide = {1'b0, a} - {1'b0, b} - cin_wide;
        else
            wide = {1'b0, a} + {1'b0, b} + cin_wide;
        sum   = wide[DATA_W-1:0];
        carry = wide[DATA_W];
    end

    // Signed overflow: the sign of the result does not fit the sign of the operands.
    always_comb begin
        if (sub)
            ovf = (a[MSB] != b[MSB]) && (sum[MSB] != a[MSB]);
        else
            ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/aau_flag_reg.sv
// Module: aau_flag_reg
// Status register for the four flags. It loads on an accepted operation
// unless the hold bit is set.
// Assumes: synchronous active-low reset clears every flag.
module aau_flag_reg
    import aau_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       hold,
    input  aau_flags_t flags_next,
    output aau_flags_t flags_q
);
    logic load_en;

    // Load on an accepted operation whose hold bit is clear.
    always_comb begin
        load_en = in_valid & ~hold;
    end

    // Flag storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= AAU_FLAGS_CLEAR;
        else if (load_en)
            flags_q <= flags_next;
    end

    AST_HOLD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hold) |=> $stable(flags_q)); // R7
    AST_IDLE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(flags_q)); // R9
endmodule

// File: rtl/aau_addsub_unit.sv
// Module: aau_addsub_unit (top)
// Add/subtract execution unit: operand select, adder, registered result
// and status register. Outputs are valid one cycle after in_valid.
// Assumes: an upstream decoder provides the mode bits with the strobe.
module aau_addsub_unit
    import aau_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              op_sub,
    input  logic              use_imm,
    input  logic              use_carry,
    input  logic              sign_ext,
    input  logic              flag_hold,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              flag_n,
    output logic              flag_c,
    output logic              flag_v,
    output logic              flag_z
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] sum;
    logic              carry;
    logic              ovf;
    logic              cin;
    aau_flags_t        flags_next;
    aau_flags_t        flags_q;

    aau_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .use_imm  (use_imm),
        .sign_ext (sign_ext),
        .reg_b    (src_b),
        .imm      (imm),
        .opnd_b   (opnd_b)
    );

    // Carry-in comes from the stored flag only when requested.
    always_comb begin
        cin = use_carry & flags_q.c;
    end

    aau_adder #(.DATA_W(DATA_W)) u_adder (
        .sub   (op_sub),
        .cin   (cin),
        .a     (src_a),
        .b     (opnd_b),
        .sum   (sum),
        .carry (carry),
        .ovf   (ovf)
    );

    // Build the next flag group from the adder outputs.
    always_comb begin
        flags_next.n = sum[MSB];
        flags_next.c = carry;
        flags_next.v = ovf;
        flags_next.z = (sum == '0);
    end

    aau_flag_reg u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .hold       (flag_hold),
        .flags_next (flags_next),
        .flags_q    (flags_q)
    );

    // Result register and valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= sum;
        end
    end

    // Drive the flag ports from the status register.
    always_comb begin
        flag_n = flags_q.n;
        flag_c = flags_q.c;
        flag_v = flags_q.v;
        flag_z = flags_q.z;
    end

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9
    AST_RESULT_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R9
    AST_ZERO_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flag_hold) |=> (flag_z == (result == '0))); // R5
    AST_NEG_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flag_hold) |=> (flag_n == result[MSB])); // R5
endmodule

// File: tb/tb_aau_addsub_unit.sv
`timescale 1ns/100ps
// Bench: sweeps an 8-bit / 4-bit-immediate instance. Expected values come
// from arithmetic in the bench, which keeps its own copy of the flags.
module tb_aau_addsub_unit;
    localparam int DW = 8;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          op_sub = 1'b0;
    logic          use_imm = 1'b0;
    logic          use_carry = 1'b0;
    logic          sign_ext = 1'b0;
    logic          flag_hold = 1'b0;
    logic [DW-1:0] src_a = '0;
    logic [DW-1:0] src_b = '0;
    logic [IW-1:0] imm = '0;
    logic          out_valid;
    logic [DW-1:0] result;
    logic          flag_n, flag_c, flag_v, flag_z;

    int checks = 0;
    int errors = 0;
    logic mn = 1'b0, mc = 1'b0, mv = 1'b0, mz = 1'b0;

    always #2.5 clk = ~clk;

    aau_addsub_unit #(.DATA_W(DW), .IMM_W(IW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .use_imm(use_imm), .use_carry(use_carry), .sign_ext(sign_ext),
        .flag_hold(flag_hold), .src_a(src_a), .src_b(src_b), .imm(imm),
        .out_valid(out_valid), .result(result), .flag_n(flag_n),
        .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One operation: drive at a falling edge, check one cycle later.
    task automatic run_op(input logic sub, input logic uc, input logic usei,
                          input logic se, input logic hold,
                          input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input logic [IW-1:0] im);
        logic [DW-1:0] bop;
        logic          cin;
        logic [DW:0]   w;
        logic [DW-1:0] r;
        logic          ov;
        string         rtag;
        string         ftag;
        bop = usei ? {{(DW-IW){se & im[IW-1]}}, im} : b;
        cin = uc & mc;
        if (sub) w = {1'b0, a} - {1'b0, bop} - {{DW{1'b0}}, cin};
        else     w = {1'b0, a} + {1'b0, bop} + {{DW{1'b0}}, cin};
        r = w[DW-1:0];
        if (sub) ov = (a[DW-1] != bop[DW-1]) && (r[DW-1] != a[DW-1]);
        else     ov = (a[DW-1] == bop[DW-1]) && (r[DW-1] != a[DW-1]);
        if (!hold) begin
            mn = r[DW-1]; mc = w[DW]; mv = ov; mz = (r == '0);
        end
        rtag = usei ? "R8" : (uc ? "R4" : (sub ? "R3" : "R2"));
        ftag = hold ? "R7" : "R5";
        in_valid = 1'b1; op_sub = sub; use_carry = uc; use_imm = usei;
        sign_ext = se; flag_hold = hold; src_a = a; src_b = b; imm = im;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9", "out_valid", int'(out_valid), 1);
        chk(rtag, "result", int'(result), int'(r));
        chk(hold ? "R7" : (uc ? "R4" : (sub ? "R3" : "R2")), "flag_c", int'(flag_c), int'(mc));
        chk(hold ? "R7" : "R6", "flag_v", int'(flag_v), int'(mv));
        chk(ftag, "flag_n", int'(flag_n), int'(mn));
        chk(ftag, "flag_z", int'(flag_z), int'(mz));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] keep_r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "result", int'(result), 0);
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "flags", int'({flag_n, flag_c, flag_v, flag_z}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: chained add, low word carries out into the high word
        run_op(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h01, '0);
        chk("R4", "low carry", int'(flag_c), 1);
        run_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, '0);
        chk("R4", "high word", int'(result), 1);
        // R3: borrow sense of carry after subtract
        run_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 8'h06, '0);
        chk("R3", "borrow set", int'(flag_c), 1);
        run_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h06, 8'h06, '0);
        chk("R3", "no borrow", int'(flag_c), 0);
        // R7: hold keeps flags while the result still changes
        run_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h01, '0);
        chk("R7", "result written", int'(result), 8'hFF);
        chk("R7", "zero kept", int'(flag_z), 1);

        // R9: idle cycle, valid drops and outputs hold
        keep_r = result;
        @(posedge clk);
        @(negedge clk);
        chk("R9", "valid low idle", int'(out_valid), 0);
        chk("R9", "result held", int'(result), int'(keep_r));

        // R2 R3 R4 R6 R7: grid over operand pairs with rotating modes
        for (int ai = 0; ai < 32; ai++) begin
            for (int bi = 0; bi < 32; bi++) begin
                logic [DW-1:0] a;
                logic [DW-1:0] b;
                a = DW'(ai * 8 + (ai % 8));
                b = DW'(bi * 8 + (bi % 8));
                run_op(1'b0, 1'(bi % 2), 1'b0, 1'b0, 1'((ai + bi) % 7 == 0), a, b, '0);
                run_op(1'b1, 1'((ai + bi) % 2), 1'b0, 1'b0, 1'((ai * bi) % 11 == 3), a, b, '0);
            end
        end

        // R8: every immediate in both extension modes, register B ignored
        for (int im = 0; im < 16; im++) begin
            for (int m = 0; m < 4; m++) begin
                for (int k = 0; k < 5; k++) begin
                    logic [DW-1:0] a;
                    case (k)
                        0: a = 8'h00;
                        1: a = 8'h01;
                        2: a = 8'h7F;
                        3: a = 8'h80;
                        default: a = 8'hFF;
                    endcase
                    run_op(1'(m % 2), 1'b0, 1'b1, 1'(m / 2), 1'b0, a, 8'hA5, IW'(im));
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule